// File: doc/BRIEF.md
# Pixel-Array Serial Readout Sequencer

This controller sits in the periphery of a photon-counting pixel chip. It walks every pixel of the array and reads each pixel's counter out over one serial line. Two one-hot shift registers select the pixel: one for the row and one for the column. For each selected pixel the sequencer issues a fixed burst of readout strobes and shifts the returned bits into a word. It then offers that word, tagged with the pixel's row and column index, on a valid/ready stream.

A `start` pulse begins a full-array scan and a one-cycle `done` pulse closes it. A chip-select input gates every action of the block, so several chips on one module can share the control lines. A scan cannot begin while the array is counting. When the downstream consumer stalls, the sequencer holds the current selection and word until the consumer takes it.

Top module: `pxl_scan_seq`

## Requirements
- R1: A `start` seen while idle, with `chip_sel` high and `count_en` low, begins a scan on the next cycle. `busy` rises, and `row_sel` and `col_sel` both select index 0 (bit 0 set, all other bits clear).
- R2: While `busy` is high exactly one bit of `row_sel` and exactly one bit of `col_sel` are set. While idle both vectors are all zero.
- R3: Pixels are visited in row-major order, with the column index varying fastest: (0,0), (0,1), … (0,COLS-1), (1,0), … up to (ROWS-1,COLS-1).
- R4: Each pixel receives exactly BITS (20) `rd_clk` strobes. `rd_bit` is captured on each strobed clock edge, most significant bit first, so the first strobe yields data bit 19.
- R5: Each output word has `out_row` and `out_col` equal to the indices of the pixel that was read, and `out_data` equal to the bits captured from it.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_row`, `out_col`, `row_sel` and `col_sel` hold their values.
- R7: While `chip_sel` is low there are no strobes, `out_valid` is low, the selection and word do not change, and `start` is ignored.
- R8: A `start` seen while `count_en` is high is ignored. The block stays idle with no pixel selected.
- R9: A `start` seen during a scan is ignored. The scan order and word count are unaffected.
- R10: `done` is high for exactly one cycle, namely the cycle after the last pixel's word is accepted. In that cycle `busy` is low, and the scan has delivered ROWS×COLS words.
- R11: After reset `busy`, `done`, `rd_clk` and `out_valid` are low, and `row_sel` and `col_sel` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Chip select; all activity is frozen while low |
| count_en | input | 1 | Array is counting; a scan may not start |
| start | input | 1 | Request a full-array scan |
| rd_bit | input | 1 | Serial bit from the selected pixel's counter |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| rd_clk | output | 1 | Readout strobe to the selected pixel |
| row_sel | output | 97 | One-hot row selection |
| col_sel | output | 60 | One-hot column selection |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_row | output | 7 | Row index of the word |
| out_col | output | 6 | Column index of the word |
| out_data | output | 20 | Pixel counter value |

## Verification
The hardest case to reach is an overlap of interruptions in the middle of a scan. These are a chip-select drop during a serial burst, a consumer stall on a pending word, and a stray `start`. The sequencer must keep both the bit position within the burst and its place in the row-major walk through all of them. A small array size is used so that several complete scans fit in the run. During those scans the random stimulus drops `chip_sel`, withdraws `out_ready` and pulses `start` independently in each cycle. A behavioural pixel model in the bench feeds bits from the one-hot selection, so any lost or repeated strobe shows up as a wrong word, tag or order.

// File: rtl/pxl_scan_pkg.sv
package pxl_scan_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SHIFT = 2'd1,
      SQ_EMIT  = 2'd2
   } seq_state_t;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pxl_onehot_walk.sv
module pxl_onehot_walk #(
   parameter int N = 60,
   localparam int W = pxl_scan_pkg::idx_w(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         clear,
   input  logic         step,
   output logic [N-1:0] sel,
   output logic [W-1:0] idx,
   output logic         at_last
);

   if (N < 2) begin : g_bad_n
      $error("pxl_onehot_walk: N must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '0;
         idx <= '0;
      end else if (load) begin
         sel <= N'(1);
         idx <= '0;
      end else if (clear) begin
         sel <= '0;
         idx <= '0;
      end else if (step) begin
         sel <= {sel[N-2:0], sel[N-1]};
         idx <= at_last ? '0 : idx + W'(1);
      end
   end

   assign at_last = (idx == W'(N - 1));

   // R2
   walk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   // R3
   walk_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|sel) |-> sel[idx]);

endmodule

// File: rtl/pxl_bit_assembler.sv
module pxl_bit_assembler #(
   parameter int BITS      = 20,
   parameter bit MSB_FIRST = 1'b1,
   localparam int CW = pxl_scan_pkg::idx_w(BITS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            strobe,
   input  logic            din,
   output logic [BITS-1:0] word,
   output logic            burst_end
);

   if (BITS < 2) begin : g_bad_bits
      $error("pxl_bit_assembler: BITS must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign burst_end = strobe && (cnt == CW'(BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (clr)       cnt <= '0;
      else if (burst_end) cnt <= '0;
      else if (strobe)    cnt <= cnt + CW'(1);
   end

   if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      word <= '0;
         else if (strobe) word <= {word[BITS-2:0], din};
      end
   end else begin : g_lsb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      word <= '0;
         else if (strobe) word <= {din, word[BITS-1:1]};
      end
   end

   // R4
   burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < BITS);

   // R4
   burst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/pxl_scan_seq.sv
module pxl_scan_seq #(
   parameter int ROWS      = 97,
   parameter int COLS      = 60,
   parameter int BITS      = 20,
   parameter bit MSB_FIRST = 1'b1,
   localparam int ROW_W = pxl_scan_pkg::idx_w(ROWS),
   localparam int COL_W = pxl_scan_pkg::idx_w(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_sel,
   input  logic             count_en,
   input  logic             start,
   input  logic             rd_bit,
   output logic             busy,
   output logic             done,
   output logic             rd_clk,
   output logic [ROWS-1:0]  row_sel,
   output logic [COLS-1:0]  col_sel,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [ROW_W-1:0] out_row,
   output logic [COL_W-1:0] out_col,
   output logic [BITS-1:0]  out_data
);
   import pxl_scan_pkg::*;

   seq_state_t state;
   logic       done_q;
   logic       go, burst_end, accept, row_last, col_last, scan_last;

   assign go        = chip_sel && (state == SQ_IDLE) && start && !count_en;
   assign rd_clk    = chip_sel && (state == SQ_SHIFT);
   assign out_valid = chip_sel && (state == SQ_EMIT);
   assign accept    = out_valid && out_ready;
   assign scan_last = row_last && col_last;
   assign busy      = (state != SQ_IDLE);
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (chip_sel) begin
            unique case (state)
               SQ_IDLE:  if (go) state <= SQ_SHIFT;
               SQ_SHIFT: if (burst_end) state <= SQ_EMIT;
               SQ_EMIT:
                  if (out_ready) begin
                     if (scan_last) begin
                        state  <= SQ_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        state <= SQ_SHIFT;
                     end
                  end
               default:  state <= SQ_IDLE;
            endcase
         end
      end
   end

   pxl_onehot_walk #(.N(ROWS)) u_row_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (go),
      .clear   (accept && scan_last),
      .step    (accept && col_last),
      .sel     (row_sel),
      .idx     (out_row),
      .at_last (row_last)
   );

   pxl_onehot_walk #(.N(COLS)) u_col_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (go),
      .clear   (accept && scan_last),
      .step    (accept),
      .sel     (col_sel),
      .idx     (out_col),
      .at_last (col_last)
   );

   pxl_bit_assembler #(.BITS(BITS), .MSB_FIRST(MSB_FIRST)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (go),
      .strobe    (rd_clk),
      .din       (rd_bit),
      .word      (out_data),
      .burst_end (burst_end)
   );

   // R2
   busy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(row_sel) == 1) && ($countones(col_sel) == 1));

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> $stable(out_data) && $stable(out_row)
                                    && $stable(out_col) && $stable(row_sel)
                                    && $stable(col_sel));

   // R7
   desel_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel |=> $stable(row_sel) && $stable(col_sel) && $stable(out_data));

   // R10
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(out_valid && out_ready));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/pxl_scan_seq_tb.sv
module pxl_scan_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ROWS  = 7;
   localparam int COLS  = 9;
   localparam int BITS  = 20;
   localparam int ROW_W = $clog2(ROWS);
   localparam int COL_W = $clog2(COLS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             chip_sel = 1'b1, count_en = 1'b0, start = 1'b0;
   logic             rd_bit, out_ready = 1'b1;
   logic             busy, done, rd_clk, out_valid;
   logic [ROWS-1:0]  row_sel;
   logic [COLS-1:0]  col_sel;
   logic [ROW_W-1:0] out_row;
   logic [COL_W-1:0] out_col;
   logic [BITS-1:0]  out_data;

   int tests = 0, fails = 0, cycles = 0;
   int scan_id = 0, pat = 0;
   int exp_r = 0, exp_c = 0, words = 0, strobes = 0, bitpos = 0;
   bit done_seen = 0, last_hs = 0, prev_done = 0, hold_prev = 0;
   logic [ROWS-1:0]  sv_row;
   logic [COLS-1:0]  sv_col;
   logic [BITS-1:0]  sv_data;
   logic [ROW_W-1:0] sv_r;
   logic [COL_W-1:0] sv_c;

   always #(CLK_PERIOD/2) clk = ~clk;

   pxl_scan_seq #(.ROWS(ROWS), .COLS(COLS), .BITS(BITS)) dut_i (
      .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .count_en(count_en),
      .start(start), .rd_bit(rd_bit), .busy(busy), .done(done),
      .rd_clk(rd_clk), .row_sel(row_sel), .col_sel(col_sel),
      .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
      .out_col(out_col), .out_data(out_data));

   function automatic logic [BITS-1:0] pixval(input int s, input int p,
                                               input int r, input int c);
      logic [31:0] x;
      x = ((32'(r) << 8) ^ 32'(c) ^ (32'(s) << 16)) * 32'h9E3779B1;
      case (p)
         1:       return '1;
         2:       return '0;
         3:       return 20'hAAAAA ^ BITS'((r << 6) | c);
         default: return x[27:8];
      endcase
   endfunction

   function automatic int oh_idx(input logic [63:0] v);
      for (int i = 0; i < 64; i++) if (v[i]) return i;
      return 0;
   endfunction

   // behavioural pixel counters: MSB first, one bit per strobe
   always_comb begin
      logic [BITS-1:0] v;
      v = pixval(scan_id, pat, oh_idx(64'(row_sel)), oh_idx(64'(col_sel)));
      rd_bit = v[BITS-1-bitpos];
   end

   always @(posedge clk or negedge rst_n)
      if (!rst_n) bitpos <= 0;
      else if (rd_clk) bitpos <= (bitpos == BITS-1) ? 0 : bitpos + 1;

   task automatic chk(input bit ok, input string tag, input longint act,
                      input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // monitor, sampled on the falling edge
   always @(negedge clk) if (rst_n) begin
      if (busy) begin
         chk($countones(row_sel) == 1, "R2 row onehot", row_sel, 0);
         chk($countones(col_sel) == 1, "R2 col onehot", col_sel, 0);
      end else begin
         chk(row_sel == '0 && col_sel == '0, "R2 idle sel", col_sel, 0);
      end
      if (!chip_sel) chk(!rd_clk && !out_valid, "R7 gated", rd_clk, 0);
      if (hold_prev)
         chk(sv_row == row_sel && sv_col == col_sel && sv_data == out_data &&
             sv_r == out_row && sv_c == out_col, "R6 hold", out_data, sv_data);
      if (done) begin
         chk(!busy, "R10 busy low", busy, 0);
         chk(words == ROWS*COLS, "R10 count", words, ROWS*COLS);
         chk(last_hs, "R10 after last", 0, 1);
         done_seen = 1;
      end
      if (prev_done) chk(!done, "R10 one cycle", done, 0);
      prev_done = done;
      if (rd_clk) strobes++;
      last_hs = 0;
      if (out_valid && out_ready) begin
         chk(strobes == BITS, "R4 strobes", strobes, BITS);
         chk(int'(out_row) == exp_r, "R3 row order", out_row, exp_r);
         chk(int'(out_col) == exp_c, "R3 col order", out_col, exp_c);
         chk(row_sel[exp_r] && col_sel[exp_c], "R5 tag vs sel", out_col, exp_c);
         chk(out_data == pixval(scan_id, pat, exp_r, exp_c), "R5 data",
             out_data, pixval(scan_id, pat, exp_r, exp_c));
         strobes = 0;
         words++;
         last_hs = (exp_r == ROWS-1) && (exp_c == COLS-1);
         if (exp_c == COLS-1) begin exp_c = 0; exp_r++; end
         else exp_c++;
      end
      hold_prev = busy && ((out_valid && !out_ready) || !chip_sel);
      sv_row = row_sel; sv_col = col_sel; sv_data = out_data;
      sv_r = out_row; sv_c = out_col;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++; tests++;
         $display("FAIL watchdog: actual %0d expected <150000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic tick;
      @(posedge clk); #1;
   endtask

   task automatic run_scan(input int p, input bit rnd);
      scan_id++; pat = p;
      exp_r = 0; exp_c = 0; words = 0; strobes = 0; done_seen = 0;
      chip_sel = 1; out_ready = 1; count_en = 0;
      tick; start = 1;
      tick; start = 0;
      // R1
      chk(busy && row_sel == ROWS'(1) && col_sel == COLS'(1), "R1 first pixel",
          {row_sel, col_sel}, 1);
      for (int n = 0; n < 20000 && !done_seen; n++) begin
         if (rnd) begin
            out_ready = ($urandom % 3) != 0;
            chip_sel  = ($urandom % 12) != 0;
            start     = busy && (($urandom % 16) == 0);  // R9 stray starts
         end
         tick;
      end
      start = 0; chip_sel = 1; out_ready = 1;
      chk(done_seen, "R10 scan finished", done_seen, 1);
      chk(words == ROWS*COLS, "R9 word total", words, ROWS*COLS);
      tick; tick;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      // R11
      chk(!busy && !done && !rd_clk && !out_valid && row_sel == '0 &&
          col_sel == '0, "R11 reset", busy, 0);
      rst_n = 1;
      tick;
      // R8: start while counting
      count_en = 1; start = 1; tick; start = 0; tick; tick;
      chk(!busy && row_sel == '0, "R8 counting start", busy, 0);
      count_en = 0;
      // R7: start while deselected
      chip_sel = 0; start = 1; tick; start = 0; tick; tick;
      chk(!busy && col_sel == '0, "R7 deselected start", busy, 0);
      chip_sel = 1; tick;
      run_scan(1, 0);
      run_scan(2, 0);
      run_scan(3, 1);
      for (int k = 0; k < 4; k++) run_scan(0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule